// File: doc/BRIEF.md
# Matrix Converter Switch State Mapper

This block turns an abstract switching state of a three-input, three-output direct AC-AC switch matrix into the nine gate commands that drive the matrix. The state is given in roles relative to the present 60° segments, not in physical phases. The caller supplies the input-segment index, the output-segment index and a state code. The code asks for one of three things: a zero state, an active state that uses input roles lead and fall, or an active state that uses input roles lead and rise. The mapper works out which physical phase fills each role and drives the matching switches.

Every output is tied to exactly one input at all times, so no output is ever left open. No two inputs share an output, so no input pair is ever shorted. Only two kinds of combination are issued. In the zero kind, all three outputs sit on one input. In the two-phase kind, exactly two outputs share an input and the third output takes another. The combination in which each output sits on a different input is never produced.

The gate word is held in a register. It changes only on the clock edge where the update strobe is high.

Top module: `mcx_switch_map`

## Requirements
- R1: After reset, and until the first update, the gate word is 9'b001001001, meaning every output is on input phase 0. Bit o*3+i of the gate word closes the switch from input i to output o.
- R2: Each output's 3-bit field of the gate word always has exactly one bit set.
- R3: The input lead role depends on the input segment k. It is phase 0 when k mod 3 = 0, phase 2 when k mod 3 = 1, and phase 1 when k mod 3 = 2. The fall role is (lead+1) mod 3 and the rise role is (lead+2) mod 3.
- R4: Output roles D, F and R are taken from the output segment with the same rule as R3. The polarity is P in even output segments and N in odd ones.
- R5: State code 0 (zero) puts all three outputs on the input lead phase.
- R6: State codes 1 and 2 are active states. They use the input pair (lead, fall) for code 1 and (lead, rise) for code 2. Under polarity P, output D takes lead and outputs F and R take the other input of the pair. Under polarity N, output D takes the other input and outputs F and R take lead. Each active state ties exactly two outputs to one input.
- R7: State code 3, or a segment index of 6 or 7 on either side, gives gate word 9'b001001001 at the next update.
- R8: The gate word changes only in the cycle after a clock edge where the update strobe is high. At other times it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Update strobe; the gate word is loaded when this is high |
| in_seg_i | input | 3 | Input-side 60° segment index (0 to 5) |
| out_seg_i | input | 3 | Output-side 60° segment index (0 to 5) |
| code_i | input | 2 | State code: 0 zero, 1 lead/fall pair, 2 lead/rise pair, 3 invalid |
| gate_o | output | 9 | Gate commands; bit o*3+i connects input i to output o |

## Verification
The vector table covers three kinds of input pattern. Zero states in segments from each residue class test the lead-role decode on its own. Active states with both pair codes, in even and odd output segments, separate a wrong polarity choice from a wrong fall/rise pick and from a wrong output-role decode. Out-of-range segment indices and the invalid code are applied after a legal word has been loaded, so that a fallback to phase 0 can be told apart from a register that simply held its old value. Changing the inputs with the strobe low tests that the word holds.

// File: rtl/mcx_pkg.sv
package mcx_pkg;
   typedef enum logic [1:0] {
      ST_ZERO   = 2'd0,
      ST_PAIR_F = 2'd1,
      ST_PAIR_R = 2'd2,
      ST_BAD    = 2'd3
   } mcx_state_e;
endpackage

// File: rtl/mcx_role_dec.sv
// Maps a 60-degree segment index to the physical phases holding the
// lead (different sign, largest), fall and rise roles.
module mcx_role_dec #(
   parameter int SEG_W = 3,
   parameter int N_SEG = 6,
   parameter int PH_W  = 2
) (
   input  logic [SEG_W-1:0] seg_i,
   output logic [PH_W-1:0]  lead_o,
   output logic [PH_W-1:0]  fall_o,
   output logic [PH_W-1:0]  rise_o,
   output logic             ok_o
);
   logic [SEG_W-1:0] res;

   always_comb begin
      res    = seg_i % SEG_W'(3);
      ok_o   = (int'(seg_i) < N_SEG);
      lead_o = '0;
      fall_o = PH_W'(1);
      rise_o = PH_W'(2);
      case (res)
         SEG_W'(0): begin lead_o = PH_W'(0); fall_o = PH_W'(1); rise_o = PH_W'(2); end
         SEG_W'(1): begin lead_o = PH_W'(2); fall_o = PH_W'(0); rise_o = PH_W'(1); end
         SEG_W'(2): begin lead_o = PH_W'(1); fall_o = PH_W'(2); rise_o = PH_W'(0); end
         default:   begin lead_o = PH_W'(0); fall_o = PH_W'(1); rise_o = PH_W'(2); end
      endcase
   end
endmodule

// File: rtl/mcx_conn_build.sv
// Builds the one-hot-per-output connection word from decoded roles.
module mcx_conn_build
   import mcx_pkg::*;
#(
   parameter int N_PH = 3,
   parameter int PH_W = 2
) (
   input  logic [PH_W-1:0]      lead_i,
   input  logic [PH_W-1:0]      fall_i,
   input  logic [PH_W-1:0]      rise_i,
   input  logic [PH_W-1:0]      od_i,
   input  mcx_state_e           code_i,
   input  logic                 pol_p_i,
   input  logic                 ok_i,
   output logic [N_PH*N_PH-1:0] word_o
);
   logic [PH_W-1:0] other;
   assign other = (code_i == ST_PAIR_F) ? fall_i : rise_i;

   for (genvar o = 0; o < N_PH; o++) begin : g_out
      logic [PH_W-1:0] src;
      always_comb begin
         if (!ok_i || code_i == ST_BAD) begin
            src = '0;
         end else if (code_i == ST_ZERO) begin
            src = lead_i;
         end else if (od_i == PH_W'(o)) begin
            src = pol_p_i ? lead_i : other;
         end else begin
            src = pol_p_i ? other : lead_i;
         end
      end
      for (genvar i = 0; i < N_PH; i++) begin : g_in
         assign word_o[o*N_PH+i] = (src == PH_W'(i));
      end
   end
endmodule

// File: rtl/mcx_switch_map.sv
module mcx_switch_map
   import mcx_pkg::*;
#(
   parameter int SEG_W     = 3,
   parameter int N_SEG     = 6,
   parameter int N_PH      = 3,
   parameter bit EVEN_IS_P = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd_i,
   input  logic [SEG_W-1:0]     in_seg_i,
   input  logic [SEG_W-1:0]     out_seg_i,
   input  logic [1:0]           code_i,
   output logic [N_PH*N_PH-1:0] gate_o
);
   localparam int PH_W = $clog2(N_PH);
   localparam int NG   = N_PH * N_PH;

   function automatic logic [NG-1:0] park_word();
      logic [NG-1:0] w;
      w = '0;
      for (int o = 0; o < N_PH; o++) w[o*N_PH] = 1'b1;
      return w;
   endfunction

   localparam logic [NG-1:0] PARK = park_word();

   if (N_PH != 3) begin : g_bad_ph
      $error("mcx_switch_map: N_PH must be 3");
   end
   if (N_SEG != 6 || (1 << SEG_W) < N_SEG) begin : g_bad_seg
      $error("mcx_switch_map: segment parameters inconsistent");
   end

   logic [PH_W-1:0] i_lead, i_fall, i_rise;
   logic [PH_W-1:0] o_lead, o_fall, o_rise;
   logic            i_ok, o_ok, pol_p;
   logic [NG-1:0]   nxt;

   mcx_role_dec #(.SEG_W(SEG_W), .N_SEG(N_SEG), .PH_W(PH_W)) in_dec_i (
      .seg_i(in_seg_i), .lead_o(i_lead), .fall_o(i_fall), .rise_o(i_rise), .ok_o(i_ok));

   mcx_role_dec #(.SEG_W(SEG_W), .N_SEG(N_SEG), .PH_W(PH_W)) out_dec_i (
      .seg_i(out_seg_i), .lead_o(o_lead), .fall_o(o_fall), .rise_o(o_rise), .ok_o(o_ok));

   if (EVEN_IS_P) begin : g_pol_even
      assign pol_p = ~out_seg_i[0];
   end else begin : g_pol_odd
      assign pol_p = out_seg_i[0];
   end

   mcx_conn_build #(.N_PH(N_PH), .PH_W(PH_W)) build_i (
      .lead_i(i_lead), .fall_i(i_fall), .rise_i(i_rise),
      .od_i(o_lead), .code_i(mcx_state_e'(code_i)), .pol_p_i(pol_p),
      .ok_i(i_ok & o_ok), .word_o(nxt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     gate_o <= PARK;
      else if (upd_i) gate_o <= nxt;
   end

   logic unused_roles;
   assign unused_roles = ^{o_fall, o_rise};
endmodule

// File: rtl/mcx_switch_map_chk.sv
module mcx_switch_map_chk #(
   parameter int N_PH = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 upd_i,
   input logic [1:0]           code_i,
   input logic [N_PH*N_PH-1:0] gate_o
);
   // R2
   out0_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gate_o[2:0]) == 1);
   // R2
   out1_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gate_o[5:3]) == 1);
   // R2
   out2_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gate_o[8:6]) == 1);
   // R6
   no_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gate_o[2:0] | gate_o[5:3] | gate_o[8:6]) <= 2);
   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(gate_o));
   // R7
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && code_i == 2'd3) |=> gate_o == 9'b001001001);
endmodule

bind mcx_switch_map mcx_switch_map_chk #(.N_PH(N_PH)) chk_i (
   .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .code_i(code_i), .gate_o(gate_o));

// File: tb/mcx_switch_map_tb.sv
module mcx_switch_map_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd = 1'b0;
   logic [2:0] in_seg = '0;
   logic [2:0] out_seg = '0;
   logic [1:0] code = '0;
   logic [8:0] gate;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mcx_switch_map dut_i (.clk(clk), .rst_n(rst_n), .upd_i(upd), .in_seg_i(in_seg),
                         .out_seg_i(out_seg), .code_i(code), .gate_o(gate));

   // {in_seg, out_seg, code, expected gate}
   localparam int NV = 12;
   localparam logic [16:0] VEC [NV] = '{
      {3'd0, 3'd0, 2'd0, 9'b001001001},  // R5 lead=0
      {3'd1, 3'd0, 2'd0, 9'b100100100},  // R3 R5 lead=2
      {3'd5, 3'd4, 2'd0, 9'b010010010},  // R3 R5 lead=1
      {3'd0, 3'd0, 2'd1, 9'b010010001},  // R6 P, pair (0,1)
      {3'd0, 3'd1, 2'd1, 9'b010001001},  // R4 N, D=out2
      {3'd2, 3'd2, 2'd2, 9'b001010001},  // R6 pair (1,0) P
      {3'd4, 3'd5, 2'd1, 9'b100001100},  // R4 N, D=out1
      {3'd3, 3'd3, 2'd2, 9'b001001100},  // R6 N pair (0,2)
      {3'd5, 3'd2, 2'd1, 9'b100010100},  // R6 P pair (1,2)
      {3'd1, 3'd0, 2'd3, 9'b001001001},  // R7 bad code
      {3'd6, 3'd0, 2'd0, 9'b001001001},  // R7 bad input seg
      {3'd2, 3'd7, 2'd1, 9'b001001001}   // R7 bad output seg
   };

   task automatic check(input logic [8:0] exp, input string req);
      n_chk++;
      if (gate !== exp) begin
         n_bad++;
         $display("FAIL %s: gate=%b expected=%b", req, gate, exp);
      end
   endtask

   task automatic apply(input logic [2:0] is, input logic [2:0] os, input logic [1:0] c);
      @(negedge clk);
      in_seg = is; out_seg = os; code = c; upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
   endtask

   initial begin
      #1500000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(9'b001001001, "R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(9'b001001001, "R1 idle after reset");

      for (int k = 0; k < NV; k++) begin
         // load a non-park word first so a stuck register is visible
         if (VEC[k][8:0] == 9'b001001001) apply(3'd1, 3'd0, 2'd0);
         apply(VEC[k][16:14], VEC[k][13:11], VEC[k][10:9]);
         check(VEC[k][8:0], $sformatf("R3-R7 vector %0d", k));
      end

      // R8: inputs change with strobe low, word holds
      apply(3'd1, 3'd0, 2'd0);
      @(negedge clk);
      in_seg = 3'd0; out_seg = 3'd0; code = 2'd1;
      repeat (3) @(negedge clk);
      check(9'b100100100, "R8 hold without strobe");
      upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
      check(9'b010010001, "R8 load on strobe");

      // R1: reset in mid-run returns to park word
      rst_n = 1'b0;
      @(negedge clk);
      check(9'b001001001, "R1 reset mid-run");
      rst_n = 1'b1;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule